// File: doc/BRIEF.md
# Interrupt and DMA Request Router

This block sits behind a logical device's configuration registers and places the device's two internal interrupt sources onto a 16-line interrupt bus and its two internal DMA request sources onto an 8-channel DMA request bus. Each line of either bus is shared with other devices. The block therefore drives, through a per-line output enable, only the lines that a select field names. Every other line is left floating for other devices to use.

Each interrupt source has a 4-bit line select and a 2-bit mode field. The mode field sets the asserted polarity and chooses level or edge triggering. Each DMA source has a 3-bit channel select and drives an active-high request. One select code on each bus means "not connected": line 0 for interrupts and channel 4 for DMA. All outputs are registered, so a change on an input shows at the ports after the next rising clock edge.

Top module: `irq_dma_router`

## Requirements
- R1: While `rst_n` is low at a rising edge, every bit of `irq_oe`, `irq_val`, `dma_oe` and `dma_val` is 0 after that edge.
- R2: An interrupt select value of 1 to 15 sets the `irq_oe` bit with that index and no other bit. Select value 0 sets no bit.
- R3: Bit 1 of an interrupt mode field is the asserted level (1 = high, 0 = low). With bit 0 = 1 (level trigger), the selected line carries the source when the asserted level is high and its inverse when it is low.
- R4: With mode bit 0 = 0 (edge trigger), a 0-to-1 change of the source, seen between two consecutive edges, holds the selected line at its asserted level for exactly one cycle. At all other times the line sits at the opposite level, and a 1-to-0 change produces no pulse.
- R5: A DMA select value of 0 to 3 or 5 to 7 sets the `dma_oe` bit with that index. Value 4 sets no bit. A driven `dma_val` bit equals the request of the source that selects it (active high).
- R6: When both sources of a bus select the same line, their active conditions are ORed. On the interrupt bus, the asserted level used for that line is the one programmed for source 0.
- R7: A bit of `irq_val` or `dma_val` whose output enable is 0 reads 0.
- R8: Outputs are registered. Inputs changed between edges do not alter the outputs until the next rising edge, and after that edge the outputs reflect the new inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_sel0 | input | 4 | Line select for interrupt source 0 (0 = none) |
| irq_sel1 | input | 4 | Line select for interrupt source 1 (0 = none) |
| irq_mode0 | input | 2 | Source 0 mode: bit 1 asserted level, bit 0 level trigger |
| irq_mode1 | input | 2 | Source 1 mode: same layout as irq_mode0 |
| dma_sel0 | input | 3 | Channel select for DMA source 0 (4 = none) |
| dma_sel1 | input | 3 | Channel select for DMA source 1 (4 = none) |
| irq_src | input | 2 | Internal interrupt sources, bit n = source n, active high |
| dma_src | input | 2 | Internal DMA requests, bit n = source n, active high |
| irq_oe | output | 16 | Per-line interrupt output enable |
| irq_val | output | 16 | Per-line interrupt driven value |
| dma_oe | output | 8 | Per-channel DMA output enable |
| dma_val | output | 8 | Per-channel DMA driven value |

## Verification
The hardest situation to reach from the ports is an edge-triggered pulse, because it depends on the source value at the previous edge as well as the current one. The bench holds a source low for a cycle, raises it between edges, and then holds it high. It confirms one asserted cycle followed by the idle level, then drops the source and confirms no pulse appears. The bench repeats this sequence in both polarities. The shared-line case with mixed polarities is reached by pointing both interrupt selects at one line with opposite mode bits, so that the level programmed for source 0 is visibly the one in force.

// File: rtl/irq_dma_pkg.sv
// Package: shared counts and mode-field layout for the request router.
// Assumes exactly two interrupt and two DMA sources per logical device.
package irq_dma_pkg;
    localparam int IRQ_SRCS = 2;
    localparam int DMA_SRCS = 2;

    // Interrupt mode field: bit 1 asserted level, bit 0 level trigger.
    typedef struct packed {
        logic act_high;
        logic level_trig;
    } irq_mode_t;
endpackage

// File: rtl/chan_decode.sv
// Module: chan_decode
// Turns a binary select into a one-hot hit vector over LINES lines.
// The code NONE_CODE maps to no hit. Purely combinational.
module chan_decode #(
    parameter int LINES     = 16,
    parameter int NONE_CODE = 0,
    localparam int SEL_W    = $clog2(LINES)
) (
    input  logic [SEL_W-1:0] sel,
    output logic [LINES-1:0] hit
);
    // One comparator per line; the reserved code never hits.
    for (genvar i = 0; i < LINES; i++) begin : g_line
        if (i == NONE_CODE) begin : g_none
            assign hit[i] = 1'b0;
        end else begin : g_cmp
            assign hit[i] = (sel == SEL_W'(i));
        end
    end

    // Guard: a select never drives more than one line.
    always_comb begin
        AST_DEC_ONEHOT: assert ($onehot0(hit)); // R2
    end
endmodule

// File: rtl/irq_cond.sv
// Module: irq_cond
// Conditions one interrupt source: level trigger passes it through,
// edge trigger yields one active cycle per rising change. The previous
// sample is always tracked so that a mode switch has a valid history.
module irq_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic src,
    input  logic level_trig,
    output logic active
);
    logic prev_q;

    // Remember the source value from the previous edge.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= src;
    end

    // Select level pass-through or rising-change detection.
    always_comb begin
        active = level_trig ? src : (src & ~prev_q);
    end

    // An edge-mode pulse lasts a single cycle while the mode holds.
    AST_EDGE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!level_trig && active) |=> (level_trig || !active)); // R4
endmodule

// File: rtl/irq_dma_router.sv
// Module: irq_dma_router
// Routes two interrupt sources onto a 16-line bus and two DMA requests
// onto an 8-channel bus. Only selected lines get their enable; shared
// lines OR their active conditions, and on the interrupt bus source 0's
// asserted level wins. All outputs are registered (one cycle latency).
module irq_dma_router #(
    parameter int IRQ_LINES  = 16,
    parameter int DMA_CHANS  = 8,
    parameter int IRQ_NONE   = 0,
    parameter int DMA_NONE   = 4,
    localparam int IRQ_SEL_W = $clog2(IRQ_LINES),
    localparam int DMA_SEL_W = $clog2(DMA_CHANS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [IRQ_SEL_W-1:0] irq_sel0,
    input  logic [IRQ_SEL_W-1:0] irq_sel1,
    input  logic [1:0]           irq_mode0,
    input  logic [1:0]           irq_mode1,
    input  logic [DMA_SEL_W-1:0] dma_sel0,
    input  logic [DMA_SEL_W-1:0] dma_sel1,
    input  logic [1:0]           irq_src,
    input  logic [1:0]           dma_src,
    output logic [IRQ_LINES-1:0] irq_oe,
    output logic [IRQ_LINES-1:0] irq_val,
    output logic [DMA_CHANS-1:0] dma_oe,
    output logic [DMA_CHANS-1:0] dma_val
);
    import irq_dma_pkg::*;

    logic [IRQ_SEL_W-1:0] isel  [IRQ_SRCS];
    irq_mode_t            imode [IRQ_SRCS];
    logic [IRQ_LINES-1:0] ihit  [IRQ_SRCS];
    logic [IRQ_SRCS-1:0]  iact;
    logic [DMA_SEL_W-1:0] dsel  [DMA_SRCS];
    logic [DMA_CHANS-1:0] dhit  [DMA_SRCS];

    logic [IRQ_LINES-1:0] irq_oe_d, irq_val_d;
    logic [DMA_CHANS-1:0] dma_oe_d, dma_val_d;

    // Gather per-source fields into indexable arrays.
    always_comb begin
        isel[0]  = irq_sel0;
        isel[1]  = irq_sel1;
        imode[0] = irq_mode0;
        imode[1] = irq_mode1;
        dsel[0]  = dma_sel0;
        dsel[1]  = dma_sel1;
    end

    for (genvar s = 0; s < IRQ_SRCS; s++) begin : g_irq
        irq_cond u_cond (
            .clk        (clk),
            .rst_n      (rst_n),
            .src        (irq_src[s]),
            .level_trig (imode[s].level_trig),
            .active     (iact[s])
        );
        chan_decode #(.LINES(IRQ_LINES), .NONE_CODE(IRQ_NONE)) u_dec (
            .sel (isel[s]),
            .hit (ihit[s])
        );
    end

    for (genvar s = 0; s < DMA_SRCS; s++) begin : g_dma
        chan_decode #(.LINES(DMA_CHANS), .NONE_CODE(DMA_NONE)) u_dec (
            .sel (dsel[s]),
            .hit (dhit[s])
        );
    end

    // Merge interrupt sources per line; lower source index sets polarity.
    always_comb begin
        for (int l = 0; l < IRQ_LINES; l++) begin
            logic en, act, pol;
            en  = 1'b0;
            act = 1'b0;
            pol = 1'b0;
            for (int s = IRQ_SRCS - 1; s >= 0; s--) begin
                if (ihit[s][l]) begin
                    en  = 1'b1;
                    act = act | iact[s];
                    pol = imode[s].act_high;
                end
            end
            irq_oe_d[l]  = en;
            irq_val_d[l] = en & ~(act ^ pol);
        end
    end

    // Merge DMA requests per channel as an active-high OR.
    always_comb begin
        for (int c = 0; c < DMA_CHANS; c++) begin
            logic en, req;
            en  = 1'b0;
            req = 1'b0;
            for (int s = 0; s < DMA_SRCS; s++) begin
                if (dhit[s][c]) begin
                    en  = 1'b1;
                    req = req | dma_src[s];
                end
            end
            dma_oe_d[c]  = en;
            dma_val_d[c] = en & req;
        end
    end

    // Register all bus-facing outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_oe  <= '0;
            irq_val <= '0;
            dma_oe  <= '0;
            dma_val <= '0;
        end else begin
            irq_oe  <= irq_oe_d;
            irq_val <= irq_val_d;
            dma_oe  <= dma_oe_d;
            dma_val <= dma_val_d;
        end
    end

    AST_IRQ_NONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_sel0 == IRQ_SEL_W'(IRQ_NONE) && irq_sel1 == IRQ_SEL_W'(IRQ_NONE))
        |=> (irq_oe == '0)); // R2
    AST_IRQ_OE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(irq_oe) <= IRQ_SRCS)); // R2
    AST_DMA_NONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_sel0 == DMA_SEL_W'(DMA_NONE) && dma_sel1 == DMA_SEL_W'(DMA_NONE))
        |=> (dma_oe == '0)); // R5
    AST_IRQ_VAL_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        ((irq_val & ~irq_oe) == '0)); // R7
    AST_DMA_VAL_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        ((dma_val & ~dma_oe) == '0)); // R7
    AST_LEVEL_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_sel0 != IRQ_SEL_W'(IRQ_NONE) && irq_sel1 != irq_sel0 && irq_mode0 == 2'b11)
        |=> (irq_val[$past(irq_sel0)] == $past(irq_src[0]))); // R3
endmodule

// File: tb/irq_dma_router_bench.sv
`timescale 1ns/1ps
module irq_dma_router_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] irq_sel0 = '0, irq_sel1 = '0;
    logic [1:0] irq_mode0 = '0, irq_mode1 = '0;
    logic [2:0] dma_sel0 = 3'd4, dma_sel1 = 3'd4;
    logic [1:0] irq_src = '0, dma_src = '0;
    logic [15:0] irq_oe, irq_val;
    logic [7:0]  dma_oe, dma_val;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    irq_dma_router u_irq_dma_router (
        .clk(clk), .rst_n(rst_n),
        .irq_sel0(irq_sel0), .irq_sel1(irq_sel1),
        .irq_mode0(irq_mode0), .irq_mode1(irq_mode1),
        .dma_sel0(dma_sel0), .dma_sel1(dma_sel1),
        .irq_src(irq_src), .dma_src(dma_src),
        .irq_oe(irq_oe), .irq_val(irq_val),
        .dma_oe(dma_oe), .dma_val(dma_val)
    );

    typedef struct packed {
        logic [3:0]  s0, s1;
        logic [1:0]  m0, m1;
        logic [2:0]  d0, d1;
        logic [1:0]  isrc, dsrc;
        logic [15:0] e_ioe, e_ival;
        logic [7:0]  e_doe, e_dval;
    } vec_t;

    // Level-trigger vectors: routing, polarity, none codes, shared lines.
    localparam int NV = 7;
    localparam vec_t VEC [NV] = '{
        '{4'd3,  4'd9,  2'b11, 2'b11, 3'd1, 3'd6, 2'b01, 2'b10, 16'h0208, 16'h0008, 8'h42, 8'h40},
        '{4'd0,  4'd15, 2'b11, 2'b01, 3'd4, 3'd0, 2'b10, 2'b11, 16'h8000, 16'h0000, 8'h01, 8'h01},
        '{4'd0,  4'd15, 2'b11, 2'b01, 3'd4, 3'd0, 2'b00, 2'b00, 16'h8000, 16'h8000, 8'h01, 8'h00},
        '{4'd5,  4'd5,  2'b11, 2'b11, 3'd7, 3'd7, 2'b10, 2'b01, 16'h0020, 16'h0020, 8'h80, 8'h80},
        '{4'd5,  4'd5,  2'b01, 2'b11, 3'd4, 3'd4, 2'b10, 2'b11, 16'h0020, 16'h0000, 8'h00, 8'h00},
        '{4'd0,  4'd0,  2'b11, 2'b11, 3'd2, 3'd3, 2'b11, 2'b01, 16'h0000, 16'h0000, 8'h0C, 8'h04},
        '{4'd1,  4'd2,  2'b01, 2'b01, 3'd0, 3'd5, 2'b01, 2'b00, 16'h0006, 16'h0004, 8'h21, 8'h00}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (3) tick();
        chk("R1 reset irq_oe", 32'(irq_oe), 32'h0);
        chk("R1 reset irq_val", 32'(irq_val), 32'h0);
        chk("R1 reset dma_oe", 32'(dma_oe), 32'h0);
        chk("R1 reset dma_val", 32'(dma_val), 32'h0);
        @(negedge clk) rst_n = 1'b1;
        tick();

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            irq_sel0 = VEC[i].s0;  irq_sel1 = VEC[i].s1;
            irq_mode0 = VEC[i].m0; irq_mode1 = VEC[i].m1;
            dma_sel0 = VEC[i].d0;  dma_sel1 = VEC[i].d1;
            irq_src = VEC[i].isrc; dma_src = VEC[i].dsrc;
            tick();
            chk($sformatf("R2 R6 vec%0d irq_oe", i), 32'(irq_oe), 32'(VEC[i].e_ioe));
            chk($sformatf("R3 R6 R7 vec%0d irq_val", i), 32'(irq_val), 32'(VEC[i].e_ival));
            chk($sformatf("R5 vec%0d dma_oe", i), 32'(dma_oe), 32'(VEC[i].e_doe));
            chk($sformatf("R5 R7 vec%0d dma_val", i), 32'(dma_val), 32'(VEC[i].e_dval));
        end

        // R8: change between edges, outputs hold until the next edge.
        @(negedge clk);
        irq_sel0 = 4'd7; irq_sel1 = 4'd0; irq_mode0 = 2'b11; irq_src = 2'b01;
        #1;
        chk("R8 hold before edge irq_oe", 32'(irq_oe), 32'h0006);
        tick();
        chk("R8 update after edge irq_oe", 32'(irq_oe), 32'h0080);
        chk("R8 update after edge irq_val", 32'(irq_val), 32'h0080);

        // R4: edge trigger, active high, on line 4.
        @(negedge clk);
        irq_sel0 = 4'd4; irq_mode0 = 2'b10; irq_src = 2'b00;
        tick();
        chk("R4 edge-high idle", 32'(irq_val), 32'h0000);
        chk("R4 edge-high oe", 32'(irq_oe), 32'h0010);
        @(negedge clk) irq_src = 2'b01;
        tick();
        chk("R4 edge-high pulse", 32'(irq_val), 32'h0010);
        tick();
        chk("R4 edge-high pulse ends", 32'(irq_val), 32'h0000);
        @(negedge clk) irq_src = 2'b00;
        tick();
        chk("R4 edge-high no pulse on fall", 32'(irq_val), 32'h0000);

        // R4: edge trigger, active low.
        @(negedge clk) irq_mode0 = 2'b00;
        tick();
        chk("R4 edge-low idle", 32'(irq_val), 32'h0010);
        @(negedge clk) irq_src = 2'b01;
        tick();
        chk("R4 edge-low pulse", 32'(irq_val), 32'h0000);
        tick();
        chk("R4 edge-low pulse ends", 32'(irq_val), 32'h0010);
        @(negedge clk) irq_src = 2'b00;
        tick();
        chk("R4 edge-low no pulse on fall", 32'(irq_val), 32'h0010);

        // R6: shared line, source 1 edge pulse ORed with source 0 level, polarity from 0.
        @(negedge clk);
        irq_sel0 = 4'd12; irq_sel1 = 4'd12; irq_mode0 = 2'b11; irq_mode1 = 2'b00; irq_src = 2'b00;
        tick();
        chk("R6 shared idle", 32'(irq_val), 32'h0000);
        @(negedge clk) irq_src = 2'b10;
        tick();
        chk("R6 shared pulse from source 1", 32'(irq_val), 32'h1000);
        tick();
        chk("R6 shared pulse ends", 32'(irq_val), 32'h0000);

        // R1: mid-run reset clears everything while sources are active.
        @(negedge clk);
        dma_sel0 = 3'd3; dma_src = 2'b01; irq_src = 2'b11; rst_n = 1'b0;
        tick();
        chk("R1 mid reset irq_oe", 32'(irq_oe), 32'h0);
        chk("R1 mid reset dma_oe", 32'(dma_oe), 32'h0);
        chk("R1 mid reset dma_val", 32'(dma_val), 32'h0);
        @(negedge clk) rst_n = 1'b1;
        tick();
        chk("R5 after reset dma_val", 32'(dma_val), 32'h08);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule